// File: doc/BRIEF.md
# Dual-Width Condition Code Generator

This block is the flag stage of a 64-bit integer ALU. From one pass over two operands and an operation code it returns the result and two condition-code groups together. The narrow group describes the low 32 bits of the result as if the operation had been 32 bits wide. The wide group describes the full 64-bit result. A branch or conditional-move unit elsewhere can then test either width without running the operation a second time.

The block is purely combinational. It handles add and subtract, both with and without an incoming carry, six logical operations, tagged add and subtract (each with a trapping form), and the one-bit multiply-step operation. The incoming carry, and the sign and overflow bits that multiply-step consumes, come from a 4-bit copy of the current narrow group. Data width, narrow width and tag width are parameters, with defaults of 64, 32 and 2.

Top module: `ccg_dualflag`

## Requirements
- R1: The flag word carries the narrow group in bits 3:0 and the wide group in bits 7:4. Inside each group, bit 0 is carry (C), bit 1 is overflow (V), bit 2 is zero (Z) and bit 3 is negative (N).
- R2: Add (op code 0) returns a+b modulo 2^WIDTH. C of the narrow group is the carry out of bit LOW-1. C of the wide group is the carry out of bit WIDTH-1. V of a group is set when both operands have the same sign bit at the group's top bit and the result's sign bit there is different.
- R3: In every operation, Z of a group is set exactly when the group's result bits (LOW or WIDTH of them) are all zero, and N copies the group's top result bit.
- R4: Subtract (op code 2) returns a-b. C of a group is the borrow, set when the group's slice of a is less than the group's slice of b (plus any incoming borrow). V of a group is set when the operand sign bits differ and the result's sign bit differs from that of a.
- R5: Add with carry (op code 1) returns a+b+cin, and subtract with borrow (op code 3) returns a-b-cin. In both, cin is bit 0 of icc_in, and the flags follow R2 and R4 respectively.
- R6: Op codes 4 to 9 select AND, OR, XOR, AND-NOT, OR-NOT and XNOR, where the NOT applies to b. They clear V and C in both groups.
- R7: Tagged add (op code 10) and tagged subtract (op code 11) compute as in R2 and R4. Narrow V is additionally set when bits TAG_BITS-1:0 of either operand are nonzero. Wide V ignores the tag bits.
- R8: Op codes 12 and 13 match codes 10 and 11 in result and flags, and raise tag_trap exactly when narrow V is set. No other op code ever raises tag_trap.
- R9: Multiply step (op code 14) adds two operands and flags the sum as in R2. The first operand is a[LOW-1:1] with the value (icc_in[3] XOR icc_in[1]) placed above it at bit LOW-1, zero-extended. The second operand is b[LOW-1:0] zero-extended when mstep_y0 is 1, and zero otherwise.
- R10: The unused op code 15 behaves exactly like add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_code | input | 4 | Operation select (codes in R2 to R10) |
| icc_in | input | 4 | Current narrow group: C carry-in, N and V for multiply step |
| mstep_y0 | input | 1 | Multiplier bit gating the second addend of multiply step |
| result | output | WIDTH | Operation result |
| flags | output | 8 | Wide group in 7:4, narrow group in 3:0 |
| tag_trap | output | 1 | Tag overflow trap request |

## Verification
The bench builds the block with WIDTH=6, LOW=3 and TAG_BITS=2. It then covers every pair of operands under every op code and four combinations of carry-in, N xor V and mstep_y0. At these widths the carry, borrow and overflow boundaries of both groups are hit at every sign and magnitude combination. So is every pattern in the tag bits, including tags that are nonzero while the arithmetic itself does not overflow, which separates R7 from R2. Expected values come from integer arithmetic in the bench, not from bit-level logic.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADDC  = 4'd1,
      OP_SUB   = 4'd2,
      OP_SUBC  = 4'd3,
      OP_AND   = 4'd4,
      OP_OR    = 4'd5,
      OP_XOR   = 4'd6,
      OP_ANDN  = 4'd7,
      OP_ORN   = 4'd8,
      OP_XNOR  = 4'd9,
      OP_TADD  = 4'd10,
      OP_TSUB  = 4'd11,
      OP_TADDT = 4'd12,
      OP_TSUBT = 4'd13,
      OP_MSTEP = 4'd14,
      OP_RSVD  = 4'd15
   } ccg_op_e;

   // bit positions inside one 4-bit group (R1)
   localparam int FLAG_C = 0;
   localparam int FLAG_V = 1;
   localparam int FLAG_Z = 2;
   localparam int FLAG_N = 3;
   localparam int GROUP_W = 4;

   function automatic logic op_is_logic(ccg_op_e op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
             (op == OP_ANDN) || (op == OP_ORN) || (op == OP_XNOR);
   endfunction

   function automatic logic op_is_tagged(ccg_op_e op);
      return (op == OP_TADD) || (op == OP_TSUB) ||
             (op == OP_TADDT) || (op == OP_TSUBT);
   endfunction

   function automatic logic op_is_trapping(ccg_op_e op);
      return (op == OP_TADDT) || (op == OP_TSUBT);
   endfunction

endpackage

// File: rtl/ccg_opsel.sv
module ccg_opsel
   import ccg_pkg::*;
#(
   parameter int WIDTH    = 64,
   parameter int LOW      = 32,
   parameter int TAG_BITS = 2
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  ccg_op_e          op,
   input  logic [3:0]       icc_in,
   input  logic             mstep_y0,
   output logic [WIDTH-1:0] add_x,
   output logic [WIDTH-1:0] add_y,
   output logic             add_cin,
   output logic             sub_mode,
   output logic             logic_mode,
   output logic             tag_err,
   output logic             trap_op
);
   localparam int HI_W = WIDTH - LOW;

   logic nv_bit;
   logic unused_icc_z;

   assign nv_bit       = icc_in[FLAG_N] ^ icc_in[FLAG_V];
   assign unused_icc_z = icc_in[FLAG_Z];

   always_comb begin
      add_x    = opnd_a;
      add_y    = opnd_b;
      add_cin  = 1'b0;
      sub_mode = 1'b0;
      case (op)
         OP_ADDC: add_cin = icc_in[FLAG_C];
         OP_SUB, OP_TSUB, OP_TSUBT: begin
            add_y    = ~opnd_b;
            add_cin  = 1'b1;
            sub_mode = 1'b1;
         end
         OP_SUBC: begin
            add_y    = ~opnd_b;
            add_cin  = ~icc_in[FLAG_C];
            sub_mode = 1'b1;
         end
         OP_MSTEP: begin
            add_x = {{HI_W{1'b0}}, nv_bit, opnd_a[LOW-1:1]};
            add_y = mstep_y0 ? {{HI_W{1'b0}}, opnd_b[LOW-1:0]} : '0;
         end
         default: ;
      endcase
   end

   assign logic_mode = op_is_logic(op);
   assign trap_op    = op_is_trapping(op);
   assign tag_err    = op_is_tagged(op) &&
                       ((|opnd_a[TAG_BITS-1:0]) || (|opnd_b[TAG_BITS-1:0]));

endmodule

// File: rtl/ccg_adder.sv
module ccg_adder #(
   parameter int WIDTH = 64,
   parameter int LOW   = 32,
   parameter bit SPLIT = 1'b1
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             c_lo,
   output logic             c_hi
);
   localparam int HI_W = WIDTH - LOW;

   generate
      if (SPLIT) begin : g_chain
         logic [LOW:0]  lo_part;
         logic [HI_W:0] hi_part;
         assign lo_part = {1'b0, x[LOW-1:0]} + {1'b0, y[LOW-1:0]} + {{LOW{1'b0}}, cin};
         assign hi_part = {1'b0, x[WIDTH-1:LOW]} + {1'b0, y[WIDTH-1:LOW]} +
                          {{HI_W{1'b0}}, lo_part[LOW]};
         assign sum  = {hi_part[HI_W-1:0], lo_part[LOW-1:0]};
         assign c_lo = lo_part[LOW];
         assign c_hi = hi_part[HI_W];
      end else begin : g_flat
         logic [WIDTH:0] full;
         logic [LOW:0]   lo_sum_unused;
         assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign lo_sum_unused = {1'b0, x[LOW-1:0]} + {1'b0, y[LOW-1:0]} +
                                {{LOW{1'b0}}, cin};
         assign sum  = full[WIDTH-1:0];
         assign c_lo = lo_sum_unused[LOW];
         assign c_hi = full[WIDTH];
      end
   endgenerate

endmodule

// File: rtl/ccg_logic.sv
module ccg_logic
   import ccg_pkg::*;
#(
   parameter int WIDTH = 64
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  ccg_op_e          op,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      case (op)
         OP_AND:  res = opnd_a & opnd_b;
         OP_OR:   res = opnd_a | opnd_b;
         OP_XOR:  res = opnd_a ^ opnd_b;
         OP_ANDN: res = opnd_a & ~opnd_b;
         OP_ORN:  res = opnd_a | ~opnd_b;
         OP_XNOR: res = ~(opnd_a ^ opnd_b);
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/ccg_flags.sv
module ccg_flags
   import ccg_pkg::*;
#(
   parameter int GW = 32
) (
   input  logic [GW-1:0]      res,
   input  logic               x_msb,
   input  logic               y_msb,
   input  logic               carry_out,
   input  logic               sub_mode,
   input  logic               arith,
   input  logic               tag_err,
   output logic [GROUP_W-1:0] nzvc
);
   logic ovf_sign;

   // y is already inverted for subtraction, so one rule covers both
   assign ovf_sign = (x_msb == y_msb) && (res[GW-1] != x_msb);

   always_comb begin
      nzvc         = '0;
      nzvc[FLAG_N] = res[GW-1];
      nzvc[FLAG_Z] = ~|res;
      nzvc[FLAG_V] = arith & (ovf_sign | tag_err);
      nzvc[FLAG_C] = arith & (carry_out ^ sub_mode);
   end
endmodule

// File: rtl/ccg_dualflag.sv
module ccg_dualflag
   import ccg_pkg::*;
#(
   parameter int WIDTH     = 64,
   parameter int LOW       = 32,
   parameter int TAG_BITS  = 2,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [3:0]       op_code,
   input  logic [3:0]       icc_in,
   input  logic             mstep_y0,
   output logic [WIDTH-1:0] result,
   output logic [7:0]       flags,
   output logic             tag_trap
);
   localparam int NGROUPS = 2;

   generate
      if (LOW < 2 || LOW >= WIDTH) begin : g_bad_low
         $error("ccg_dualflag: LOW must be in [2, WIDTH-1]");
      end
      if (TAG_BITS < 1 || TAG_BITS >= LOW) begin : g_bad_tag
         $error("ccg_dualflag: TAG_BITS must be in [1, LOW-1]");
      end
   endgenerate

   ccg_op_e          op;
   logic [WIDTH-1:0] add_x, add_y, sum, logic_res;
   logic             add_cin, sub_mode, logic_mode, tag_err, trap_op;
   logic             c_lo, c_hi;
   logic [GROUP_W-1:0] grp [NGROUPS];

   assign op = ccg_op_e'(op_code);

   ccg_opsel #(.WIDTH(WIDTH), .LOW(LOW), .TAG_BITS(TAG_BITS)) u_opsel (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .op(op), .icc_in(icc_in),
      .mstep_y0(mstep_y0), .add_x(add_x), .add_y(add_y), .add_cin(add_cin),
      .sub_mode(sub_mode), .logic_mode(logic_mode), .tag_err(tag_err),
      .trap_op(trap_op)
   );

   ccg_adder #(.WIDTH(WIDTH), .LOW(LOW), .SPLIT(SPLIT_ADD)) u_adder (
      .x(add_x), .y(add_y), .cin(add_cin), .sum(sum), .c_lo(c_lo), .c_hi(c_hi)
   );

   ccg_logic #(.WIDTH(WIDTH)) u_logic (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .op(op), .res(logic_res)
   );

   assign result = logic_mode ? logic_res : sum;

   // group 0: narrow (LOW bits), group 1: wide (WIDTH bits)
   generate
      for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
         localparam int GW = (g == 0) ? LOW : WIDTH;
         ccg_flags #(.GW(GW)) u_flags (
            .res(result[GW-1:0]),
            .x_msb(add_x[GW-1]),
            .y_msb(add_y[GW-1]),
            .carry_out((g == 0) ? c_lo : c_hi),
            .sub_mode(sub_mode),
            .arith(~logic_mode),
            .tag_err((g == 0) ? tag_err : 1'b0),
            .nzvc(grp[g])
         );
      end
   endgenerate

   assign flags    = {grp[1], grp[0]};
   assign tag_trap = trap_op & grp[0][FLAG_V];

endmodule

// File: rtl/ccg_checker.sv
module ccg_checker
   import ccg_pkg::*;
#(
   parameter int WIDTH    = 64,
   parameter int LOW      = 32,
   parameter int TAG_BITS = 2
) (
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [3:0]       op_code,
   input logic [7:0]       flags,
   input logic [WIDTH-1:0] result,
   input logic             tag_trap
);
   logic [WIDTH-1:0] plain_sum;
   assign plain_sum = opnd_a + opnd_b;

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, op_code})) begin
         // R6: logical ops clear V and C in both groups
         a_r6_logic_clear: assert (!op_is_logic(ccg_op_e'(op_code)) ||
                                   (flags[1:0] == 2'b00 && flags[5:4] == 2'b00))
            else $error("R6 logical op left V/C set");
         // R8: trap only from trapping tagged ops with narrow V
         a_r8_trap_source: assert (!tag_trap ||
                                   (op_is_trapping(ccg_op_e'(op_code)) && flags[1]))
            else $error("R8 spurious tag trap");
         // R3: zero and negative follow the result bits
         a_r3_zero_narrow: assert (flags[2] == (result[LOW-1:0] == '0))
            else $error("R3 narrow Z wrong");
         a_r3_neg_wide: assert (flags[7] == result[WIDTH-1])
            else $error("R3 wide N wrong");
         // R2: add returns the modular sum
         a_r2_add_sum: assert (op_code != 4'd0 || result == plain_sum)
            else $error("R2 add result wrong");
         // R7: nonzero tag bits force narrow V on tagged ops
         a_r7_tag_ovf: assert (!op_is_tagged(ccg_op_e'(op_code)) ||
                               ((opnd_a[TAG_BITS-1:0] | opnd_b[TAG_BITS-1:0]) == '0) ||
                               flags[1])
            else $error("R7 tag bits did not set V");
      end
   end
endmodule

bind ccg_dualflag ccg_checker #(.WIDTH(WIDTH), .LOW(LOW), .TAG_BITS(TAG_BITS)) u_chk (
   .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code), .flags(flags),
   .result(result), .tag_trap(tag_trap)
);

// File: tb/sim_ccg_dualflag.sv
`timescale 1ns/1ps
module sim_ccg_dualflag;
   localparam int W = 6;
   localparam int L = 3;
   localparam int T = 2;

   logic         clk = 1'b0;
   logic [W-1:0] opnd_a, opnd_b, result;
   logic [3:0]   op_code, icc_in;
   logic         mstep_y0, tag_trap;
   logic [7:0]   flags;
   int           n_vec = 0;
   int           n_bad = 0;
   bit           done  = 1'b0;

   always #2.5 clk = ~clk;

   ccg_dualflag #(.WIDTH(W), .LOW(L), .TAG_BITS(T), .SPLIT_ADD(1'b1)) u0 (
      .opnd_a(opnd_a), .opnd_b(opnd_b), .op_code(op_code), .icc_in(icc_in),
      .mstep_y0(mstep_y0), .result(result), .flags(flags), .tag_trap(tag_trap)
   );

   function automatic string req_of(int op);
      case (op)
         0:  return "R2";
         1:  return "R5 add-carry";
         2:  return "R4";
         3:  return "R5 sub-borrow";
         4, 5, 6, 7, 8, 9: return "R6";
         10, 11: return "R7";
         12, 13: return "R8";
         14: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic longint bitn(longint v, int n);
      return (v >> (n - 1)) & 1;
   endfunction

   task automatic apply(int op, int a, int b, int k);
      longint mW = (64'd1 << W) - 1;
      longint mL = (64'd1 << L) - 1;
      longint x, y, c, r;
      longint clo, chi, vlo, vhi;
      bit     is_sub, is_logic;
      bit     cin = k[0];
      bit     nv  = k[1];
      bit     y0  = k[0] ^ k[1];
      bit     e_trap;
      logic [7:0] e_flags;
      x = a; y = b; c = 0; is_sub = 0; is_logic = 0;
      clo = 0; chi = 0; vlo = 0; vhi = 0; r = 0;
      case (op)
         1:  c = cin;
         2, 11, 13: is_sub = 1;
         3:  begin is_sub = 1; c = cin; end
         4, 5, 6, 7, 8, 9: is_logic = 1;
         14: begin
            x = (longint'(nv) << (L - 1)) | ((a & mL) >> 1);
            y = y0 ? (b & mL) : 0;
         end
         default: ;
      endcase
      if (is_logic) begin
         case (op)
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            7: r = a & ~b;
            8: r = a | ~b;
            default: r = ~(a ^ b);
         endcase
         r = r & mW;
      end else if (is_sub) begin
         r   = (x - y - c) & mW;
         clo = ((x & mL) < ((y & mL) + c)) ? 1 : 0;
         chi = (x < (y + c)) ? 1 : 0;
         vlo = (bitn(x, L) != bitn(y, L) && bitn(r, L) != bitn(x, L)) ? 1 : 0;
         vhi = (bitn(x, W) != bitn(y, W) && bitn(r, W) != bitn(x, W)) ? 1 : 0;
      end else begin
         r   = (x + y + c) & mW;
         clo = (((x & mL) + (y & mL) + c) >> L) & 1;
         chi = ((x + y + c) >> W) & 1;
         vlo = (bitn(x, L) == bitn(y, L) && bitn(r, L) != bitn(x, L)) ? 1 : 0;
         vhi = (bitn(x, W) == bitn(y, W) && bitn(r, W) != bitn(x, W)) ? 1 : 0;
      end
      if (op >= 10 && op <= 13 && (((a | b) & ((1 << T) - 1)) != 0)) vlo = 1;
      e_trap = (op == 12 || op == 13) && (vlo != 0);
      // R1 layout: {N,Z,V,C} wide in 7:4, narrow in 3:0
      e_flags = {bitn(r, W) != 0, (r & mW) == 0, vhi != 0, chi != 0,
                 bitn(r, L) != 0, (r & mL) == 0, vlo != 0, clo != 0};

      opnd_a   = W'(a);
      opnd_b   = W'(b);
      op_code  = 4'(op);
      icc_in   = {nv, 1'b0, 1'b0, cin};
      mstep_y0 = y0;
      #1;
      n_vec++;
      if (result !== W'(r) || flags !== e_flags || tag_trap !== e_trap) begin
         n_bad++;
         $display("FAIL %s R1/R3 op=%0d a=%0d b=%0d k=%0d: got res=%0d flags=%b trap=%b, exp res=%0d flags=%b trap=%b",
                  req_of(op), op, a, b, k, result, flags, tag_trap, r, e_flags, e_trap);
      end
   endtask

   initial begin
      // reset-like state: all-zero add gives Z in both groups (R1, R3)
      apply(0, 0, 0, 0);
      for (int op = 0; op < 16; op++)
         for (int k = 0; k < 4; k++)
            for (int a = 0; a < (1 << W); a++)
               for (int b = 0; b < (1 << W); b++)
                  apply(op, a, b, k);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #600000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule